// File: doc/BRIEF.md
# NAND Host Operation Sequencer

This block sits on the host side of a raw 8-bit NAND flash bus. It takes a single high-level request and turns it into the matching bus cycles. The request is a page read, a page program, a block erase, a status read or a device reset. The block drives chip enable, the command and address latch strobes, the write and read strobes, and the I/O byte lane. Program data comes in on a byte stream and read data goes out on another.

Once a program or erase has been confirmed, the sequencer watches the ready/busy line. When the array operation completes, it issues a status query and reads one status byte. It then reports the outcome as a one-cycle done pulse with a fail flag. A timeout on the ready/busy wait also ends the operation as failed. The strobe timing is set by parameters:

- clocks that a write or read strobe is held low;
- minimum clocks it is held high;
- busy timeout, in clocks.

Top module: `nand_op_seq`

## Requirements
- R1: A page read (req_op code 0) issues command 00h, then column low, column high, row low and row high address bytes, then command 30h. It waits for ready/busy, then pulses the read strobe req_len times and delivers the bytes in order on rd_data with rd_valid. fail is 0 unless the wait timed out.
- R2: A page program (code 1) issues 80h and the four address bytes. It then issues req_len data bytes taken in order from the write stream, one byte for each wr_ready pulse, followed by 10h.
- R3: A block erase (code 2) issues 60h, then only the row low and row high bytes with no column bytes, then D0h.
- R4: After the confirm byte of a program or erase, the block waits for ready/busy to go low and then high. It then issues 70h and reads one byte with the read strobe. fail at done equals bit 0 of that byte.
- R5: A status read (code 3) issues 70h, reads one byte, presents it once on rd_data with rd_valid, and sets fail to its bit 0. A reset (code 4) issues FFh, waits for ready/busy low then high, and finishes with fail 0.
- R6: Bus timing rules:
  - each write or read strobe is held low for exactly STROBE_LO clocks;
  - the write and read strobes are never low together;
  - command latch and address latch are never high together;
  - chip enable is low whenever a strobe is low;
  - the I/O lane is not driven while the read strobe is low;
  - latches and I/O byte stay stable while the write strobe is low.
- R7: If ready/busy does not complete its low-then-high sequence within BUSY_TIMEOUT clocks, the operation ends with fail 1 and no status query is issued.
- R8: A request is accepted only while busy is low and req_op is 0 to 4. busy rises the cycle after acceptance and falls the cycle after done. Requests made while busy, or with codes 5 to 7, produce no bus activity.
- R9: After reset: chip enable high, both strobes high, both latches low, I/O lane not driven, busy and done low.
- R10: done is high for exactly one cycle per accepted request, and fail is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code (0 read, 1 program, 2 erase, 3 status, 4 reset) |
| req_col | input | 16 | Column address |
| req_row | input | 16 | Row address |
| req_len | input | 12 | Byte count for read or program, up to MAX_LEN |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Outcome, valid with done |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data byte available |
| wr_ready | output | 1 | Program data byte taken this cycle |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read data byte valid |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Byte driven onto the I/O lane |
| nand_io_oe | output | 1 | I/O lane output enable |
| nand_io_in | input | 8 | Byte sampled from the I/O lane |
| nand_rb_n | input | 1 | Ready/busy from the device, low while busy |

## Verification
The assertions take for granted two things about the inputs. Requests arrive as single-cycle pulses with a steady operation code. The device answers a confirm byte by holding ready/busy low for a bounded time, so every accepted request reaches done. The bench's flash model drops ready/busy a few clocks after each confirm byte and holds it low for a fixed stretch, well inside the timeout. It withholds that response only in the scenario that tests the timeout. The write stream keeps its data valid at all times.

// File: rtl/nand_seq_pkg.sv
// Shared operation codes, sequencer states and command byte tables.
package nand_seq_pkg;

    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_PROG   = 3'd1,
        OP_ERASE  = 3'd2,
        OP_STATUS = 3'd3,
        OP_RESET  = 3'd4
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD1,
        S_ADDR,
        S_WDATA,
        S_CMD2,
        S_WAIT,
        S_SCMD,
        S_SREAD,
        S_RDATA,
        S_DONE
    } st_e;

    localparam logic [7:0] CMD_STATUS = 8'h70;

    // Opening command byte for each operation.
    function automatic logic [7:0] first_cmd(op_e op);
        case (op)
            OP_READ:   return 8'h00;
            OP_PROG:   return 8'h80;
            OP_ERASE:  return 8'h60;
            OP_STATUS: return CMD_STATUS;
            default:   return 8'hFF;
        endcase
    endfunction

    // Confirm byte that starts the array operation.
    function automatic logic [7:0] confirm_cmd(op_e op);
        case (op)
            OP_READ:  return 8'h30;
            OP_PROG:  return 8'h10;
            OP_ERASE: return 8'hD0;
            default:  return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/nand_strobe_gen.sv
// Strobe generator: one bus cycle per start pulse.
// Drives the write or read strobe low for STROBE_LO clocks, then high for
// STROBE_HI clocks. 'sample' marks the last low clock and 'fin' marks the
// last high clock. Assumes start is raised only while idle.
module nand_strobe_gen #(
    parameter int unsigned STROBE_LO = 2,
    parameter int unsigned STROBE_HI = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rd_mode,
    output logic we_n,
    output logic re_n,
    output logic sample,
    output logic fin,
    output logic idle
);
    localparam int unsigned TMAX = (STROBE_LO > STROBE_HI) ? STROBE_LO : STROBE_HI;
    localparam int unsigned CW   = (TMAX < 2) ? 1 : $clog2(TMAX);
    localparam logic [CW-1:0] LO_LAST = CW'(STROBE_LO - 1);
    localparam logic [CW-1:0] HI_LAST = CW'(STROBE_HI - 1);

    localparam logic [1:0] PH_IDLE = 2'd0;
    localparam logic [1:0] PH_LOW  = 2'd1;
    localparam logic [1:0] PH_HIGH = 2'd2;

    logic [1:0]    ph;
    logic [CW-1:0] cnt;
    logic          rd_q;

    // Phase and clock count of the current bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph   <= PH_IDLE;
            cnt  <= '0;
            rd_q <= 1'b0;
        end else begin
            case (ph)
                PH_IDLE: if (start) begin
                    ph   <= PH_LOW;
                    cnt  <= '0;
                    rd_q <= rd_mode;
                end
                PH_LOW: if (cnt == LO_LAST) begin
                    ph  <= PH_HIGH;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                PH_HIGH: if (cnt == HI_LAST) begin
                    ph  <= PH_IDLE;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // Strobe levels and phase markers decoded from the phase register.
    always_comb begin
        idle   = (ph == PH_IDLE);
        sample = (ph == PH_LOW)  && (cnt == LO_LAST);
        fin    = (ph == PH_HIGH) && (cnt == HI_LAST);
        we_n   = !((ph == PH_LOW) && !rd_q);
        re_n   = !((ph == PH_LOW) &&  rd_q);
    end

endmodule

// File: rtl/nand_rb_wait.sv
// Ready/busy waiter. While 'en' is high it synchronises nand_rb_n through
// RB_SYNC flops and looks for a low level followed by a high level.
// Raises 'ok' when that has happened. Raises 'tmo' if BUSY_TIMEOUT clocks
// pass first. Dropping 'en' clears its progress. Assumes RB_SYNC >= 2.
module nand_rb_wait #(
    parameter int unsigned BUSY_TIMEOUT = 65536,
    parameter int unsigned RB_SYNC      = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic rb_n,
    output logic ok,
    output logic tmo
);
    localparam int unsigned TW = $clog2(BUSY_TIMEOUT + 1);
    localparam logic [TW-1:0] T_LAST = TW'(BUSY_TIMEOUT - 1);

    logic [RB_SYNC-1:0] sr;
    logic [TW-1:0]      cnt;
    logic               seen_lo;
    logic               rb_s;

    genvar g;
    generate
        for (g = 0; g < RB_SYNC; g++) begin : g_sync
            // One synchroniser stage for the asynchronous ready/busy line.
            always_ff @(posedge clk) begin
                if (!rst_n) sr[g] <= 1'b1;
                else if (g == 0) sr[g] <= rb_n;
                else sr[g] <= sr[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    assign rb_s = sr[RB_SYNC-1];

    // Elapsed clocks and whether the busy level has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt     <= '0;
            seen_lo <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
            if (!rb_s) seen_lo <= 1'b1;
        end
    end

    // Completion and timeout flags.
    always_comb begin
        ok  = en && seen_lo && rb_s;
        tmo = en && !ok && (cnt == T_LAST);
    end

endmodule

// File: rtl/nand_addr_sel.sv
// Address byte selector. Packs the row above the column and returns byte
// 'idx', so column bytes come out before row bytes, low byte first.
module nand_addr_sel #(
    parameter int unsigned COL_BYTES = 2,
    parameter int unsigned ROW_BYTES = 2
) (
    input  logic [8*COL_BYTES-1:0]                 col,
    input  logic [8*ROW_BYTES-1:0]                 row,
    input  logic [$clog2(COL_BYTES+ROW_BYTES)-1:0] idx,
    output logic [7:0]                             byte_o
);
    localparam int unsigned NB = COL_BYTES + ROW_BYTES;

    logic [8*NB-1:0] packed_addr;

    // Byte lookup within the packed address.
    always_comb begin
        packed_addr = {row, col};
        byte_o      = packed_addr[8*idx +: 8];
    end

endmodule

// File: rtl/nand_op_seq.sv
// NAND host operation sequencer (top).
// Accepts one request while idle and steps through a sequence of bus
// cycles: command, address, data, confirm, busy wait, status poll, read
// data. One strobe generator times every bus cycle. Assumes req_len does
// not exceed MAX_LEN and the write stream offers bytes when asked.
module nand_op_seq
    import nand_seq_pkg::*;
#(
    parameter int unsigned STROBE_LO    = 2,
    parameter int unsigned STROBE_HI    = 2,
    parameter int unsigned BUSY_TIMEOUT = 65536,
    parameter int unsigned COL_BYTES    = 2,
    parameter int unsigned ROW_BYTES    = 2,
    parameter int unsigned MAX_LEN      = 2112,
    parameter int unsigned RB_SYNC      = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    input  logic [2:0]                      req_op,
    input  logic [8*COL_BYTES-1:0]          req_col,
    input  logic [8*ROW_BYTES-1:0]          req_row,
    input  logic [$clog2(MAX_LEN+1)-1:0]    req_len,
    output logic                            busy,
    output logic                            done,
    output logic                            fail,
    input  logic [7:0]                      wr_data,
    input  logic                            wr_valid,
    output logic                            wr_ready,
    output logic [7:0]                      rd_data,
    output logic                            rd_valid,
    output logic                            nand_ce_n,
    output logic                            nand_cle,
    output logic                            nand_ale,
    output logic                            nand_we_n,
    output logic                            nand_re_n,
    output logic [7:0]                      nand_io_out,
    output logic                            nand_io_oe,
    input  logic [7:0]                      nand_io_in,
    input  logic                            nand_rb_n
);
    localparam int unsigned COL_W      = 8 * COL_BYTES;
    localparam int unsigned ROW_W      = 8 * ROW_BYTES;
    localparam int unsigned ADDR_BYTES = COL_BYTES + ROW_BYTES;
    localparam int unsigned AIW        = $clog2(ADDR_BYTES);
    localparam int unsigned LEN_W      = $clog2(MAX_LEN + 1);
    localparam logic [AIW-1:0] A_LAST  = AIW'(ADDR_BYTES - 1);
    localparam logic [AIW-1:0] A_ROW0  = AIW'(COL_BYTES);

    st_e              state;
    op_e              op_q;
    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] row_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] byte_cnt;
    logic [AIW-1:0]   addr_idx;
    logic [7:0]       wbyte;
    logic [7:0]       addr_byte;
    logic             fail_q;
    logic             busy_q;
    logic             last_byte;
    logic             op_ok;

    logic bus_wr, bus_rd;
    logic strb_start, strb_sample, strb_fin, strb_idle;
    logic rb_en, rb_ok, rb_tmo;

    nand_strobe_gen #(
        .STROBE_LO (STROBE_LO),
        .STROBE_HI (STROBE_HI)
    ) u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (strb_start),
        .rd_mode (bus_rd),
        .we_n    (nand_we_n),
        .re_n    (nand_re_n),
        .sample  (strb_sample),
        .fin     (strb_fin),
        .idle    (strb_idle)
    );

    nand_rb_wait #(
        .BUSY_TIMEOUT (BUSY_TIMEOUT),
        .RB_SYNC      (RB_SYNC)
    ) u_rbwait (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (rb_en),
        .rb_n  (nand_rb_n),
        .ok    (rb_ok),
        .tmo   (rb_tmo)
    );

    nand_addr_sel #(
        .COL_BYTES (COL_BYTES),
        .ROW_BYTES (ROW_BYTES)
    ) u_addr (
        .col    (col_q),
        .row    (row_q),
        .idx    (addr_idx),
        .byte_o (addr_byte)
    );

    // Bus cycle classification, strobe launch and pin values for the state.
    always_comb begin
        bus_wr = (state == S_CMD1) || (state == S_ADDR) || (state == S_WDATA) ||
                 (state == S_CMD2) || (state == S_SCMD);
        bus_rd = (state == S_SREAD) || (state == S_RDATA);
        strb_start = strb_idle &&
                     ((bus_wr && ((state != S_WDATA) || wr_valid)) || bus_rd);
        wr_ready  = strb_start && (state == S_WDATA);
        rb_en     = (state == S_WAIT);
        last_byte = (byte_cnt == len_q - LEN_W'(1));
        op_ok     = (req_op <= 3'd4);
        nand_cle  = (state == S_CMD1) || (state == S_CMD2) || (state == S_SCMD);
        nand_ale  = (state == S_ADDR);
        nand_io_oe = bus_wr;
        case (state)
            S_CMD1:  nand_io_out = first_cmd(op_q);
            S_ADDR:  nand_io_out = addr_byte;
            S_WDATA: nand_io_out = wbyte;
            S_CMD2:  nand_io_out = confirm_cmd(op_q);
            S_SCMD:  nand_io_out = CMD_STATUS;
            default: nand_io_out = 8'h00;
        endcase
        nand_ce_n = !busy_q;
        busy      = busy_q;
        done      = (state == S_DONE);
        fail      = fail_q;
    end

    // Latch of the program byte taken from the write stream.
    always_ff @(posedge clk) begin
        if (!rst_n) wbyte <= 8'h00;
        else if (wr_ready) wbyte <= wr_data;
    end

    // Read data and status capture at the last low clock of a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= 8'h00;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (strb_sample && ((state == S_RDATA) ||
                                (state == S_SREAD && op_q == OP_STATUS))) begin
                rd_data  <= nand_io_in;
                rd_valid <= 1'b1;
            end
        end
    end

    // Operation sequencing: request capture, step order and outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            op_q     <= OP_READ;
            col_q    <= '0;
            row_q    <= '0;
            len_q    <= '0;
            byte_cnt <= '0;
            addr_idx <= '0;
            fail_q   <= 1'b0;
            busy_q   <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (req_valid && op_ok) begin
                    op_q     <= op_e'(req_op);
                    col_q    <= req_col;
                    row_q    <= req_row;
                    len_q    <= req_len;
                    byte_cnt <= '0;
                    addr_idx <= (op_e'(req_op) == OP_ERASE) ? A_ROW0 : '0;
                    fail_q   <= 1'b0;
                    busy_q   <= 1'b1;
                    state    <= S_CMD1;
                end
                S_CMD1: if (strb_fin) begin
                    case (op_q)
                        OP_STATUS: state <= S_SREAD;
                        OP_RESET:  state <= S_WAIT;
                        default:   state <= S_ADDR;
                    endcase
                end
                S_ADDR: if (strb_fin) begin
                    addr_idx <= addr_idx + 1'b1;
                    if (addr_idx == A_LAST)
                        state <= (op_q == OP_PROG && len_q != '0) ? S_WDATA : S_CMD2;
                end
                S_WDATA: if (strb_fin) begin
                    byte_cnt <= last_byte ? '0 : byte_cnt + 1'b1;
                    if (last_byte) state <= S_CMD2;
                end
                S_CMD2: if (strb_fin) state <= S_WAIT;
                S_WAIT: begin
                    if (rb_ok) begin
                        case (op_q)
                            OP_READ:  state <= (len_q == '0) ? S_DONE : S_RDATA;
                            OP_RESET: state <= S_DONE;
                            default:  state <= S_SCMD;
                        endcase
                    end else if (rb_tmo) begin
                        fail_q <= 1'b1;
                        state  <= S_DONE;
                    end
                end
                S_SCMD: if (strb_fin) state <= S_SREAD;
                S_SREAD: begin
                    if (strb_sample) fail_q <= nand_io_in[0];
                    if (strb_fin) state <= S_DONE;
                end
                S_RDATA: if (strb_fin) begin
                    byte_cnt <= byte_cnt + 1'b1;
                    if (last_byte) state <= S_DONE;
                end
                S_DONE: begin
                    busy_q <= 1'b0;
                    state  <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nand_op_seq_chk.sv
// Protocol checker for nand_op_seq, attached by bind. It watches only
// the top-level ports and keeps its own strobe-width counter.
module nand_op_seq_chk #(
    parameter int unsigned STROBE_LO = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [2:0] req_op,
    input logic       busy,
    input logic       done,
    input logic       nand_ce_n,
    input logic       nand_cle,
    input logic       nand_ale,
    input logic       nand_we_n,
    input logic       nand_re_n,
    input logic [7:0] nand_io_out,
    input logic       nand_io_oe
);
    logic [15:0] we_lo_cnt;
    logic [15:0] re_lo_cnt;

    // Lengths of the current write and read strobe low pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_lo_cnt <= '0;
            re_lo_cnt <= '0;
        end else begin
            we_lo_cnt <= nand_we_n ? '0 : we_lo_cnt + 1'b1;
            re_lo_cnt <= nand_re_n ? '0 : re_lo_cnt + 1'b1;
        end
    end

    // R6
    we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> (we_lo_cnt == 16'(STROBE_LO)));
    // R6
    re_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_re_n) |-> (re_lo_cnt == 16'(STROBE_LO)));
    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));
    // R6
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));
    // R6
    ce_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
    // R6
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_io_oe);
    // R6
    we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n && $past(!nand_we_n)) |->
            ($stable(nand_io_out) && $stable(nand_cle) && $stable(nand_ale)));
    // R8
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_op <= 3'd4) |=> busy);
    // R8
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

endmodule

bind nand_op_seq nand_op_seq_chk #(.STROBE_LO(STROBE_LO)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .busy        (busy),
    .done        (done),
    .nand_ce_n   (nand_ce_n),
    .nand_cle    (nand_cle),
    .nand_ale    (nand_ale),
    .nand_we_n   (nand_we_n),
    .nand_re_n   (nand_re_n),
    .nand_io_out (nand_io_out),
    .nand_io_oe  (nand_io_oe)
);

// File: tb/test_nand_op_seq.sv
// Directed bench for nand_op_seq with a small behavioural flash model.
module test_nand_op_seq;
    localparam int TLO = 3;
    localparam int THI = 2;
    localparam int TMO = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [15:0] req_col = '0;
    logic [15:0] req_row = '0;
    logic [11:0] req_len = '0;
    logic        busy, done, fail;
    logic [7:0]  wr_data;
    logic        wr_valid = 1'b1;
    logic        wr_ready;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [7:0]  nand_io_out;
    logic [7:0]  nand_io_in = 8'h00;
    logic        nand_rb_n;

    always #4 clk = ~clk;

    nand_op_seq #(
        .STROBE_LO (TLO),
        .STROBE_HI (THI),
        .BUSY_TIMEOUT (TMO)
    ) i_nand_op_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_col(req_col), .req_row(req_row), .req_len(req_len),
        .busy(busy), .done(done), .fail(fail),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
        .nand_io_in(nand_io_in), .nand_rb_n(nand_rb_n)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // ---------------- flash model ----------------
    logic [9:0] log_mem [0:1023];
    int   wptr = 0;
    logic [7:0] last_cmd = 8'hFF;
    int   rd_idx = 0;
    logic [7:0] stat_val = 8'hE0;
    bit   no_rb = 0;
    int   conf_evt = 0;
    int   conf_seen = 0;
    int   rb_timer = 0;
    int   ce_err = 0;

    // Bus cycle logging on each rising write strobe.
    always @(posedge nand_we_n) begin
        if (rst_n) begin
            if (nand_ce_n) ce_err++;
            log_mem[wptr % 1024] = {nand_cle, nand_ale, nand_io_out};
            wptr++;
            if (nand_cle) begin
                last_cmd = nand_io_out;
                if (nand_io_out == 8'h00) rd_idx = 0;
                if (nand_io_out == 8'h30 || nand_io_out == 8'h10 ||
                    nand_io_out == 8'hD0 || nand_io_out == 8'hFF) conf_evt++;
            end
        end
    end

    // Device output byte on each falling read strobe.
    always @(negedge nand_re_n) begin
        if (rst_n) begin
            if (last_cmd == 8'h70) nand_io_in = stat_val;
            else begin
                nand_io_in = 8'(rd_idx * 13 + 5);
                rd_idx++;
            end
        end
    end

    // Ready/busy response: low for 20 clocks, starting a few clocks after a confirm.
    always @(posedge clk) begin
        if (conf_evt != conf_seen) begin
            conf_seen = conf_evt;
            if (!no_rb) rb_timer = 25;
        end else if (rb_timer > 0) rb_timer--;
    end
    assign nand_rb_n = !(rb_timer > 0 && rb_timer <= 20);

    // ---------------- streams ----------------
    logic [7:0] wr_base = 8'hA0;
    int wr_idx = 0;
    assign wr_data = wr_base + 8'(wr_idx);
    always @(posedge clk) if (wr_ready) wr_idx <= wr_idx + 1;

    logic [7:0] rd_buf [0:255];
    int rd_cnt = 0;
    always @(posedge clk) if (rd_valid) begin
        rd_buf[rd_cnt % 256] <= rd_data;
        rd_cnt <= rd_cnt + 1;
    end

    // Strobe width monitor (R6).
    int we_lo = 0, re_lo = 0, width_err = 0;
    always @(posedge clk) begin
        if (!nand_we_n) we_lo++;
        else begin
            if (we_lo != 0 && we_lo != TLO) width_err++;
            we_lo = 0;
        end
        if (!nand_re_n) re_lo++;
        else begin
            if (re_lo != 0 && re_lo != TLO) width_err++;
            re_lo = 0;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_log(string req, int base, int k, logic [9:0] exp);
        chk(req, $sformatf("bus cycle %0d", k), 32'(log_mem[(base + k) % 1024]), 32'(exp));
    endtask

    logic last_fail;
    int   done_cnt;

    task automatic run_op(input logic [2:0] op, input logic [15:0] col,
                          input logic [15:0] row, input logic [11:0] len);
        @(negedge clk);
        while (busy) @(negedge clk);
        req_op = op; req_col = col; req_row = row; req_len = len;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        done_cnt = 0;
        while (!done) @(negedge clk);
        last_fail = fail;
        @(negedge clk);
        if (done) done_cnt++;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_state();
        chk("R9", "ce_n", 32'(nand_ce_n), 1);
        chk("R9", "we_n/re_n", 32'({nand_we_n, nand_re_n}), 32'h3);
        chk("R9", "cle/ale/oe", 32'({nand_cle, nand_ale, nand_io_oe}), 0);
        chk("R9", "busy/done", 32'({busy, done}), 0);
    endtask

    task automatic t_read();
        int base = wptr; int rb = rd_cnt;
        run_op(3'd0, 16'h0123, 16'h4567, 12'd5);
        chk("R1", "cycle count", 32'(wptr - base), 6);
        chk_log("R1", base, 0, {2'b10, 8'h00});
        chk_log("R1", base, 1, {2'b01, 8'h23});
        chk_log("R1", base, 2, {2'b01, 8'h01});
        chk_log("R1", base, 3, {2'b01, 8'h67});
        chk_log("R1", base, 4, {2'b01, 8'h45});
        chk_log("R1", base, 5, {2'b10, 8'h30});
        chk("R1", "read byte count", 32'(rd_cnt - rb), 5);
        for (int i = 0; i < 5; i++)
            chk("R1", $sformatf("read byte %0d", i), 32'(rd_buf[(rb + i) % 256]), 32'(8'(i * 13 + 5)));
        chk("R1", "fail", 32'(last_fail), 0);
        chk("R10", "done single cycle", 32'(done_cnt), 0);
        chk("R8", "busy after done", 32'(busy), 0);
    endtask

    task automatic t_program(input logic [7:0] sv, input logic exp_fail);
        int base = wptr;
        stat_val = sv;
        wr_idx = 0;
        run_op(3'd1, 16'h0800, 16'h00C1, 12'd4);
        chk("R2", "cycle count", 32'(wptr - base), 11);
        chk_log("R2", base, 0, {2'b10, 8'h80});
        chk_log("R2", base, 1, {2'b01, 8'h00});
        chk_log("R2", base, 2, {2'b01, 8'h08});
        chk_log("R2", base, 3, {2'b01, 8'hC1});
        chk_log("R2", base, 4, {2'b01, 8'h00});
        for (int i = 0; i < 4; i++) chk_log("R2", base, 5 + i, {2'b00, 8'hA0 + 8'(i)});
        chk_log("R2", base, 9, {2'b10, 8'h10});
        chk_log("R4", base, 10, {2'b10, 8'h70});
        chk("R4", "program fail flag", 32'(last_fail), 32'(exp_fail));
    endtask

    task automatic t_erase(input logic [7:0] sv, input logic exp_fail);
        int base = wptr;
        stat_val = sv;
        run_op(3'd2, 16'hFFFF, 16'h0302, 12'd0);
        chk("R3", "cycle count", 32'(wptr - base), 5);
        chk_log("R3", base, 0, {2'b10, 8'h60});
        chk_log("R3", base, 1, {2'b01, 8'h02});
        chk_log("R3", base, 2, {2'b01, 8'h03});
        chk_log("R3", base, 3, {2'b10, 8'hD0});
        chk_log("R4", base, 4, {2'b10, 8'h70});
        chk("R4", "erase fail flag", 32'(last_fail), 32'(exp_fail));
    endtask

    task automatic t_status();
        int base = wptr; int rb = rd_cnt;
        stat_val = 8'hC1;
        run_op(3'd3, 16'h0, 16'h0, 12'd0);
        chk("R5", "status cycle count", 32'(wptr - base), 1);
        chk_log("R5", base, 0, {2'b10, 8'h70});
        chk("R5", "status byte count", 32'(rd_cnt - rb), 1);
        chk("R5", "status byte", 32'(rd_buf[rb % 256]), 32'hC1);
        chk("R5", "status fail", 32'(last_fail), 1);
    endtask

    task automatic t_reset_op();
        int base = wptr;
        run_op(3'd4, 16'h0, 16'h0, 12'd0);
        chk("R5", "reset cycle count", 32'(wptr - base), 1);
        chk_log("R5", base, 0, {2'b10, 8'hFF});
        chk("R5", "reset fail", 32'(last_fail), 0);
    endtask

    task automatic t_timeout();
        int base = wptr;
        no_rb = 1;
        wr_idx = 0;
        stat_val = 8'hE0;
        run_op(3'd1, 16'h0000, 16'h0010, 12'd1);
        no_rb = 0;
        chk("R7", "cycles without status poll", 32'(wptr - base), 7);
        chk_log("R7", base, 6, {2'b10, 8'h10});
        chk("R7", "timeout fail", 32'(last_fail), 1);
    endtask

    task automatic t_busy_ignore();
        int base = wptr;
        @(negedge clk);
        req_op = 3'd7; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8", "bad code not accepted", 32'(busy), 0);
        repeat (4) @(negedge clk);
        chk("R8", "bad code no bus cycle", 32'(wptr - base), 0);
        req_op = 3'd0; req_col = 16'h0004; req_row = 16'h0005; req_len = 12'd2;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (10) @(negedge clk);
        chk("R8", "busy during op", 32'(busy), 1);
        req_op = 3'd2; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        repeat (20) @(negedge clk);
        chk("R8", "only read cycles", 32'(wptr - base), 6);
        chk_log("R8", base, 0, {2'b10, 8'h00});
        chk("R8", "idle after ignored request", 32'(busy), 0);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset_state();
        t_read();
        t_program(8'hE0, 1'b0);
        t_program(8'hE1, 1'b1);
        t_erase(8'hE0, 1'b0);
        t_erase(8'hE1, 1'b1);
        t_status();
        t_reset_op();
        t_timeout();
        t_busy_ignore();
        chk("R6", "strobe low width errors", 32'(width_err), 0);
        chk("R6", "strobe with chip disabled", 32'(ce_err), 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule